// File: doc/BRIEF.md
# Oscillator Clock Recovery Trimmer

This block keeps a fast, trimmable oscillator locked to a slower reference pulse train. A clock-enable strobe `osc_tick` stands for one cycle of that oscillator inside the single system clock domain. A 16-bit error counter starts at a programmed reload value and counts oscillator cycles down to zero. If the oscillator is fast, the counter passes zero and then counts up. On every qualified sync event the counter value and its direction are captured. The captured error is graded against a programmable limit, and a 7-bit trim code may then be stepped toward the target. After the capture the counter is loaded again.

A sync event can come from one of three hardware inputs: an external pin, a low-speed crystal output or a USB start-of-frame pulse. The chosen input is taken on its rising or its falling edge, then divided by a power of two from 1 to 128. A software pulse can also stand in for a hardware sync edge. Software reaches the block through a small register port with three locations: control, configuration, and a status word that is cleared by writing ones. A single interrupt line combines the four flag groups, each through its own enable.

Top module: `clk_recovery_trim`

## Requirements
- R1: After reset:
  - control (address 0) reads 0x00004000: counter off, auto-trim off, all interrupt enables 0, trim code 64 in bits 14:8.
  - configuration (address 1) reads 0x1022BB7F: reload in bits 15:0, limit in bits 23:16, divider code in bits 26:24, source in bits 28:27 with 0 = pin, 1 = crystal, 2 or 3 = start-of-frame, polarity in bit 29.
  - status (address 2) reads 0.
- R2: With control bit 0 set, each `osc_tick` moves the counter one step, first down from the reload value. A sync event copies the counter into status bits 31:16 and a direction bit into status bit 15, then reloads the counter. The direction bit is 1 while still counting down (slow oscillator) and 0 once counting up (fast oscillator).
- R3: The expected-sync flag (status bit 3) is set on the tick that brings the down-count to zero. From that point the counter counts up.
- R4: At a sync event the captured error e is graded against the limit L:
  - e ≤ L sets sync-ok (bit 0).
  - L < e < 3L sets sync-warning (bit 1).
  - e ≥ 3L sets sync-error (bit 4).
- R5: Sync-missed (bit 5) is set when the up-count reaches 3L with no sync event in between.
- R6: With auto-trim on (control bit 1), an ok grade steps the trim code by 1 if e is nonzero and by 0 if e is zero. A warning grade steps it by 2, and a sync-error grade leaves it unchanged. The step lowers the code for a fast oscillator and raises it for a slow one. With auto-trim off the code never changes on a sync event.
- R7: A trim step that would go below 0 or above 127 clamps the code at that end and sets trim-overflow (bit 6).
- R8: Only the selected source produces sync events. With polarity bit 1, the falling edge of that source counts and the rising edge does not.
- R9: A divider code d turns every 2^d qualified edges into one sync event.
- R10: A one-cycle pulse on `sw_sync` acts as a sync event immediately, without the divider.
- R11: Writes to the configuration location are ignored while the counter enable or the auto-trim enable is set.
- R12: Writing address 2 clears flags by writing ones: bit 0 clears ok, bit 1 clears warning, bit 3 clears expected-sync, and bit 2 clears sync-error, sync-missed and trim-overflow together. Status bit 2 reads as the OR of those three.
- R13: `irq` is high exactly when an enabled flag group is set. The enables are control bits 2..5, for ok, warning, error summary and expected-sync in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One pulse per oscillator cycle |
| sync_pin | input | 1 | External pin sync source |
| sync_xtal | input | 1 | Low-speed crystal sync source |
| sync_sof | input | 1 | USB start-of-frame sync source |
| sw_sync | input | 1 | Software sync pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 config, 2 clear) |
| wr_data | input | 30 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 config, 2 status) |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
The main sweep runs one trial for every tick count from 0 to 40 between sync edges, using reload 20 and limit 2. This covers a slow oscillator, an exactly tuned one, and one fast enough to miss the window. It therefore separates all grade boundaries, both directions and the missed threshold, and follows the trim code as it builds up over the trials. Further patterns drive:
- a starting trim of 126 or 1, to force clamping at each end;
- a pulse on a source that is not selected;
- a falling-edge pulse train through a divide-by-two;
- a software pulse;
- configuration writes while the block is locked.

// File: rtl/clk_recovery_trim.sv
module clk_recovery_trim #(
  parameter logic [15:0] RELOAD_RST = 16'hBB7F,
  parameter logic [7:0]  LIMIT_RST  = 8'h22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_tick,
  input  logic        sync_pin,
  input  logic        sync_xtal,
  input  logic        sync_sof,
  input  logic        sw_sync,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [29:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq
);
  localparam int CW = 16;
  localparam int LW = 8;
  localparam int TW = 7;
  localparam int XW = CW + 2;
  localparam int TRIM_MAX = (1 << TW) - 1;
  localparam int TRIM_MID = 1 << (TW - 1);

  logic          cnt_en, auto_en, pol, up, dir_q, sync_q;
  logic [3:0]    ie;
  logic [TW-1:0] trim;
  logic [CW-1:0] reload, cnt, cap;
  logic [LW-1:0] lim;
  logic [2:0]    div;
  logic [1:0]    src;
  logic [6:0]    pre;
  logic          f_ok, f_warn, f_esync, f_serr, f_miss, f_tovf;

  wire sel     = (src == 2'd0) ? sync_pin : (src == 2'd1) ? sync_xtal : sync_sof;
  wire edge_hw = (sel ^ pol) & ~sync_q;
  wire [6:0] pre_top = 7'((32'd1 << div) - 32'd1);
  wire sync_evt = cnt_en & ((edge_hw & (pre == pre_top)) | sw_sync);
  wire f_err = f_serr | f_miss | f_tovf;

  wire [XW-1:0] lim3  = XW'(lim) + XW'(lim) + XW'(lim);
  wire [XW-1:0] cntx  = XW'(cnt);
  wire g_ok   = cntx <= XW'(lim);
  wire g_warn = !g_ok && (cntx < lim3);
  wire [1:0] step = g_ok ? ((cnt != '0) ? 2'd1 : 2'd0) : (g_warn ? 2'd2 : 2'd0);

  int  tsum;
  logic t_ovf;
  logic [TW-1:0] trim_nx;
  always_comb begin
    tsum  = up ? int'(trim) - int'(step) : int'(trim) + int'(step);
    t_ovf = (tsum < 0) || (tsum > TRIM_MAX);
    if (tsum < 0)             trim_nx = '0;
    else if (tsum > TRIM_MAX) trim_nx = TW'(TRIM_MAX);
    else                      trim_nx = TW'(tsum);
  end

  wire wr_ctl = wr_en && wr_addr == 2'd0;
  wire wr_cfg = wr_en && wr_addr == 2'd1 && !cnt_en && !auto_en;
  wire wr_clr = wr_en && wr_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en <= 1'b0; auto_en <= 1'b0; ie <= '0; trim <= TW'(TRIM_MID);
      reload <= RELOAD_RST; lim <= LIMIT_RST; div <= '0; src <= 2'd2; pol <= 1'b0;
    end else begin
      if (wr_ctl) begin
        cnt_en  <= wr_data[0];
        auto_en <= wr_data[1];
        ie      <= wr_data[5:2];
        if (!auto_en) trim <= wr_data[14:8];
      end
      if (wr_cfg) begin
        reload <= wr_data[15:0];
        lim    <= wr_data[23:16];
        div    <= wr_data[26:24];
        src    <= wr_data[28:27];
        pol    <= wr_data[29];
      end
      if (sync_evt && auto_en && step != 2'd0) trim <= trim_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0; pre <= '0;
    end else begin
      sync_q <= sel ^ pol;
      if (!cnt_en)      pre <= '0;
      else if (edge_hw) pre <= (pre == pre_top) ? '0 : pre + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; up <= 1'b0; cap <= '0; dir_q <= 1'b0;
      {f_ok, f_warn, f_esync, f_serr, f_miss, f_tovf} <= '0;
    end else begin
      if (wr_clr) begin
        if (wr_data[0]) f_ok    <= 1'b0;
        if (wr_data[1]) f_warn  <= 1'b0;
        if (wr_data[2]) {f_serr, f_miss, f_tovf} <= '0;
        if (wr_data[3]) f_esync <= 1'b0;
      end
      if (!cnt_en) begin
        cnt <= reload; up <= 1'b0;
      end else if (sync_evt) begin
        cap <= cnt; dir_q <= ~up;
        cnt <= reload; up <= 1'b0;
        if (g_ok)        f_ok   <= 1'b1;
        else if (g_warn) f_warn <= 1'b1;
        else             f_serr <= 1'b1;
        if (auto_en && step != 2'd0 && t_ovf) f_tovf <= 1'b1;
      end else if (osc_tick) begin
        if (!up) begin
          if (cnt <= CW'(1)) begin
            cnt <= '0; up <= 1'b1; f_esync <= 1'b1;
          end else cnt <= cnt - CW'(1);
        end else begin
          if (cnt != '1) cnt <= cnt + CW'(1);
          if (cntx + XW'(1) == lim3) f_miss <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {17'd0, trim, 2'd0, ie, auto_en, cnt_en};
      2'd1:    rd_data = {2'd0, pol, src, div, lim, reload};
      2'd2:    rd_data = {cap, dir_q, 8'd0, f_tovf, f_miss, f_serr, f_esync, f_err, f_warn, f_ok};
      default: rd_data = '0;
    endcase
  end

  assign irq = (ie[0] & f_ok) | (ie[1] & f_warn) | (ie[2] & f_err) | (ie[3] & f_esync);

  AST_RELOAD_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> (cnt == $past(reload)) && !up) else $error("reload after sync"); // R2
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en || auto_en) |=> $stable(reload) && $stable(lim) && $stable(div)) else $error("config lock"); // R11
  AST_TRIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en |=> (int'(trim) - int'($past(trim)) <= 2) && (int'($past(trim)) - int'(trim) <= 2)) else $error("trim step"); // R6
  AST_ONE_GRADE: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(f_ok) && $rose(f_warn))) else $error("two grades"); // R4
  AST_MISS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_miss) |-> up) else $error("miss while down"); // R5
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (f_ok | f_warn | f_err | f_esync)) else $error("irq source"); // R13
endmodule

// File: tb/clk_recovery_trim_tb.sv
module clk_recovery_trim_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RL = 20;
  localparam int LM = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_tick = 0, sync_pin = 0, sync_xtal = 0, sync_sof = 0, sw_sync = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [29:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;
  int exp_trim;

  clk_recovery_trim u_dut (.clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sync_pin(sync_pin),
    .sync_xtal(sync_xtal), .sync_sof(sync_sof), .sw_sync(sw_sync), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [29:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic ticks(input int n);
    osc_tick = 1;
    repeat (n) @(negedge clk);
    osc_tick = 0;
  endtask

  task automatic pin_pulse();
    sync_pin = 1; @(negedge clk); sync_pin = 0; @(negedge clk);
  endtask

  function automatic logic [31:0] model(input int k, input int rl, input int lm, inout int tr, input bit auto_on);
    int e; bit dn, esy, miss, ok, warn, serr, tovf; int st, t;
    dn = k < rl; e = dn ? rl - k : k - rl; esy = !dn;
    miss = !dn && (3*lm > 0) && (e >= 3*lm);
    ok = e <= lm; warn = !ok && e < 3*lm; serr = !ok && !warn;
    st = ok ? (e != 0 ? 1 : 0) : (warn ? 2 : 0);
    tovf = 0;
    if (auto_on && st != 0) begin
      t = dn ? tr + st : tr - st;
      if (t < 0) begin t = 0; tovf = 1; end
      if (t > 127) begin t = 127; tovf = 1; end
      tr = t;
    end
    return {e[15:0], dn, 8'd0, tovf, miss, serr, esy, (serr|miss|tovf), warn, ok};
  endfunction

  initial begin
    logic [31:0] d, e;
    int wd_tr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d); check("R1 control", d, 32'h0000_4000);
    rd(1, d); check("R1 config", d, 32'h1022_BB7F);
    rd(2, d); check("R1 status", d, 32'h0);

    wr(1, 30'(RL | (LM << 16)));
    wr(0, 30'(3 | (64 << 8)));
    exp_trim = 64;
    for (int k = 0; k <= 40; k++) begin
      wr(2, 30'hF);
      ticks(k);
      pin_pulse();
      e = model(k, RL, LM, exp_trim, 1);
      rd(2, d); check($sformatf("R2 R3 R4 R5 sweep k=%0d", k), d, e);
      rd(0, d); check($sformatf("R6 trim k=%0d", k), 32'(d[14:8]), 32'(exp_trim));
    end
    // last trial left error, missed and expected-sync set
    wr(2, 30'h4);
    rd(2, d); check("R12 error group clear", 32'(d[6:0]), 32'h08);

    wr(1, 30'h0);
    rd(1, d); check("R11 config locked", d, 32'(RL | (LM << 16)));

    wr(0, 30'(3 | (1 << 2)));
    wr(2, 30'hF);
    check("R13 irq low", 32'(irq), 0);
    ticks(RL + 1); pin_pulse();
    check("R13 irq on ok", 32'(irq), 1);
    wr(2, 30'h1);
    check("R13 irq cleared", 32'(irq), 0);
    exp_trim = exp_trim - 1;

    wr(2, 30'hF);
    ticks(RL);
    sw_sync = 1; @(negedge clk); sw_sync = 0; @(negedge clk);
    rd(2, d); check("R10 software sync", d, 32'h0000_0009);

    wr(2, 30'hF);
    ticks(RL - 1);
    sync_xtal = 1; @(negedge clk); sync_xtal = 0; @(negedge clk);
    rd(2, d); check("R8 unselected source ignored", 32'(d[6:0]), 32'h0);

    wr(0, 30'(exp_trim << 8));
    wr(1, 30'(RL | (LM << 16) | (1 << 24) | (1 << 27) | (1 << 29)));
    sync_xtal = 1; @(negedge clk);
    wr(0, 30'(1 | (exp_trim << 8)));
    wr(2, 30'hF);
    ticks(RL - 1);
    sync_xtal = 0; @(negedge clk); sync_xtal = 1; @(negedge clk);
    rd(2, d); check("R9 first divided edge no event", 32'(d[6:0]), 32'h0);
    sync_xtal = 0; @(negedge clk); sync_xtal = 1; @(negedge clk);
    rd(2, d); check("R8 R9 falling edge event", d, 32'h0001_8001);
    rd(0, d); check("R6 no trim step with auto off", 32'(d[14:8]), 32'(exp_trim));

    wr(0, 30'(126 << 8));
    wr(1, 30'(RL | (LM << 16)));
    wr(0, 30'(3 | (126 << 8)));
    wr(2, 30'hF);
    ticks(RL - 3); pin_pulse();
    rd(2, d); check("R7 overflow high", 32'(d[6:0]), 32'h46);
    rd(0, d); check("R7 clamp 127", 32'(d[14:8]), 127);

    wr(0, 30'(1 << 8));
    wr(0, 30'(3 | (1 << 8)));
    wr(2, 30'hF);
    ticks(RL + 3); pin_pulse();
    rd(2, d); check("R7 underflow low", 32'(d[6:0]), 32'h4E);
    rd(0, d); check("R7 clamp 0", 32'(d[14:8]), 0);

    wd_tr = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule